// File: doc/BRIEF.md
# Split-Capable Load/Store Unit

This unit sits between a 32-bit core's execute stage and a data bus with request, grant and response phases. The core hands it one access at a time: an address, an access size, a direction, store data and a flag that selects sign or zero extension for loads. The unit turns that access into aligned bus transfers, each with byte enables. A load or store that spills past the end of a data word becomes two transfers: the word holding the start address goes first, then the following word. The read words are merged, shifted down to bit 0 and extended. The unit then returns one result with one error bit.

The core side is a valid/ready stream. The core raises `req_valid_i` with its fields and holds all of them steady until a clock edge at which `req_ready_o` is also high. `req_ready_o` is high only while the unit has no access in flight. The completion side is a one-cycle pulse on `rsp_valid_o` that cannot be back-pressured, so the core must take the result in the cycle it is offered. The bus side keeps one transfer outstanding at a time. It holds each request until it is granted. It waits for the matching response, and only then moves to the second half or completes. Responses that arrive while nothing is outstanding are dropped.

Top module: `ldst_unit`

## Requirements
- R1: After reset `req_ready_o` is high. An access is accepted at a clock edge where `req_valid_i` and `req_ready_o` are both high. In the next cycle `bus_req_o` is high and `req_ready_o` is low, and `req_ready_o` stays low until the access completes.
- R2: `req_size_i` uses 00 for a byte, 01 for a halfword and 10 for a word. An access whose bytes all fall in one word makes exactly one transfer. That transfer has `bus_addr_o` equal to the address with bits [1:0] cleared. `bus_be_o` bit k is set for each byte lane k from the offset (address bits [1:0]) up to offset+size-1. Store byte i sits in lane offset+i of `bus_wdata_o`.
- R3: An access that runs past lane 3 makes two transfers, in order. The first goes to the aligned word, with enables from the offset up to lane 3. The second goes to that word plus 4, with enables on the low lanes that hold the remaining bytes. Store data is split across the two transfers the same way.
- R4: While `bus_req_o` is high and `bus_gnt_i` is low, `bus_req_o`, `bus_addr_o`, `bus_be_o`, `bus_we_o` and `bus_wdata_o` keep their values into the next cycle.
- R5: The unit moves past a request only on a cycle where `bus_req_o` and `bus_gnt_i` are both high. A `bus_rvalid_i` pulse that arrives before the grant of the pending transfer does not change the result or the error flag.
- R6: A `bus_rvalid_i` pulse, with or without `bus_err_i`, that arrives while no access is in flight produces no completion and leaves `req_ready_o` high.
- R7: A load returns its bytes little-endian, from address upward, starting at bit 0. A byte or halfword is sign-extended when `req_signed_i` is 1 and zero-extended when it is 0. A store completes with `rsp_rdata_o` equal to zero.
- R8: If the first transfer of a split access gets an error response, the second transfer is still issued. The completion comes only after both responses have arrived, and it carries `rsp_err_o` high.
- R9: Each access produces exactly one `rsp_valid_o` pulse, one cycle long. The pulse comes in the cycle after the final response. `rsp_err_o` is the OR of the error inputs of the responses to this access.
- R10: `bus_req_o` has no combinational path from `bus_rvalid_i` or `bus_err_i`. While the first-half response is being presented, `bus_req_o` is low. The second-half request appears in the following cycle.
- R11: During reset `rsp_valid_o` and `bus_req_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Core offers an access |
| req_ready_o | output | 1 | Unit can accept an access |
| req_we_i | input | 1 | 1 for store, 0 for load |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 00 byte, 01 halfword, 10 word |
| req_signed_i | input | 1 | Sign-extend a narrow load |
| req_wdata_i | input | DATA_W | Store data, least significant byte first |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Aligned and extended load data |
| rsp_err_o | output | 1 | Any transfer of the access failed |
| bus_req_o | output | 1 | Bus transfer request |
| bus_gnt_i | input | 1 | Bus accepts the request |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | ADDR_W | Word-aligned bus address |
| bus_be_o | output | DATA_W/8 | Byte lane enables |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rvalid_i | input | 1 | Response valid |
| bus_rdata_i | input | DATA_W | Response read data |
| bus_err_i | input | 1 | Response carries an error |

## Verification
The bench aims at accesses that start at every byte offset. Halfwords at offset 3 and words at offsets 1 to 3 are the ones that split. A unit that mis-decided the split would issue one transfer and lose the bytes in the next word, or would merge the two responses in the wrong order. Errors are injected on the first half only, on the second half only and on both. A unit that gave up after a failed first half would show one transfer and an early completion, and one that dropped the second error would report a clean result. Grants are stalled at random and stray response pulses are sent while idle and while a request waits for its grant. A unit that moved on without a grant, or that took a stray response, would show a changed address during the stall, a wrong result or an extra completion. The bench also samples the request line while a first-half response is being presented, to catch a combinational path from the response inputs to the request.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ_LO = 3'd1,
    ST_RSP_LO = 3'd2,
    ST_REQ_HI = 3'd3,
    ST_RSP_HI = 3'd4
  } ldst_state_e;

  // Number of bytes an access of the given size touches.
  function automatic int size_bytes(input logic [1:0] sz, input int word_bytes);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return word_bytes;
    endcase
  endfunction

endpackage

// File: rtl/ldst_lane_map.sv
// Spreads one access over two consecutive words: byte enables and store data.
module ldst_lane_map #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BYTES-1:0]  be_lo_o,
  output logic [BYTES-1:0]  be_hi_o,
  output logic [DATA_W-1:0] wdata_lo_o,
  output logic [DATA_W-1:0] wdata_hi_o,
  output logic              split_o
);

  logic [2*BYTES-1:0]  lane_mask;
  logic [2*BYTES-1:0]  lane_span;
  logic [2*DATA_W-1:0] wide_data;
  int                  nbytes;

  always_comb nbytes = ldst_pkg::size_bytes(size_i, BYTES);

  for (genvar g = 0; g < 2*BYTES; g++) begin : g_mask
    assign lane_mask[g] = (g < nbytes);
  end

  always_comb begin
    lane_span = lane_mask << off_i;
    wide_data = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};
  end

  assign be_lo_o    = lane_span[BYTES-1:0];
  assign be_hi_o    = lane_span[2*BYTES-1:BYTES];
  assign wdata_lo_o = wide_data[DATA_W-1:0];
  assign wdata_hi_o = wide_data[2*DATA_W-1:DATA_W];
  assign split_o    = |lane_span[2*BYTES-1:BYTES];

endmodule

// File: rtl/ldst_read_align.sv
// Joins the response words, moves the addressed bytes to bit 0 and extends them.
module ldst_read_align #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic              split_i,
  input  logic [DATA_W-1:0] word_lo_i,
  input  logic [DATA_W-1:0] word_hi_i,
  output logic [DATA_W-1:0] data_o
);

  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   low_part;

  always_comb begin
    joined   = split_i ? {word_hi_i, word_lo_i} : {{DATA_W{1'b0}}, word_lo_i};
    shifted  = joined >> {off_i, 3'b000};
    low_part = shifted[DATA_W-1:0];
    case (size_i)
      ldst_pkg::SZ_BYTE: data_o = {{(DATA_W-8){signed_i & low_part[7]}}, low_part[7:0]};
      ldst_pkg::SZ_HALF: data_o = {{(DATA_W-16){signed_i & low_part[15]}}, low_part[15:0]};
      default:           data_o = low_part;
    endcase
  end

endmodule

// File: rtl/ldst_unit.sv
// Load/store unit: splits word-crossing accesses into two aligned bus transfers.
module ldst_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BYTES-1:0]  bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_rvalid_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_err_i
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BYTES);

  ldst_pkg::ldst_state_e state_q, state_d;

  logic              we_q, signed_q, split_q, err_lo_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [BYTES-1:0]  be_lo_q, be_hi_q;
  logic [DATA_W-1:0] wd_lo_q, wd_hi_q, rdata_lo_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  // Lane mapping of the incoming request, captured on accept.
  logic [BYTES-1:0]  map_be_lo, map_be_hi;
  logic [DATA_W-1:0] map_wd_lo, map_wd_hi;
  logic              map_split;

  ldst_lane_map #(.DATA_W(DATA_W)) u_lane_map (
    .off_i      (req_addr_i[OFF_W-1:0]),
    .size_i     (req_size_i),
    .wdata_i    (req_wdata_i),
    .be_lo_o    (map_be_lo),
    .be_hi_o    (map_be_hi),
    .wdata_lo_o (map_wd_lo),
    .wdata_hi_o (map_wd_hi),
    .split_o    (map_split)
  );

  // Handshake qualifiers
  logic accept, granted, resp_lo, resp_hi, finish, in_hi;

  assign req_ready_o = (state_q == ldst_pkg::ST_IDLE);
  assign bus_req_o   = (state_q == ldst_pkg::ST_REQ_LO) || (state_q == ldst_pkg::ST_REQ_HI);
  assign accept      = req_valid_i && req_ready_o;
  assign granted     = bus_req_o && bus_gnt_i;
  assign resp_lo     = (state_q == ldst_pkg::ST_RSP_LO) && bus_rvalid_i;
  assign resp_hi     = (state_q == ldst_pkg::ST_RSP_HI) && bus_rvalid_i;
  assign finish      = (resp_lo && !split_q) || resp_hi;
  assign in_hi       = (state_q == ldst_pkg::ST_REQ_HI);

  // Read merge
  logic [DATA_W-1:0] merged;

  ldst_read_align #(.DATA_W(DATA_W)) u_read_align (
    .off_i     (off_q),
    .size_i    (size_q),
    .signed_i  (signed_q),
    .split_i   (split_q),
    .word_lo_i ((state_q == ldst_pkg::ST_RSP_HI) ? rdata_lo_q : bus_rdata_i),
    .word_hi_i (bus_rdata_i),
    .data_o    (merged)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ldst_pkg::ST_IDLE:   if (accept)  state_d = ldst_pkg::ST_REQ_LO;
      ldst_pkg::ST_REQ_LO: if (granted) state_d = ldst_pkg::ST_RSP_LO;
      ldst_pkg::ST_RSP_LO: if (resp_lo) state_d = split_q ? ldst_pkg::ST_REQ_HI : ldst_pkg::ST_IDLE;
      ldst_pkg::ST_REQ_HI: if (granted) state_d = ldst_pkg::ST_RSP_HI;
      ldst_pkg::ST_RSP_HI: if (resp_hi) state_d = ldst_pkg::ST_IDLE;
      default:                          state_d = ldst_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ldst_pkg::ST_IDLE;
      we_q        <= 1'b0;
      signed_q    <= 1'b0;
      split_q     <= 1'b0;
      err_lo_q    <= 1'b0;
      base_q      <= '0;
      off_q       <= '0;
      size_q      <= '0;
      be_lo_q     <= '0;
      be_hi_q     <= '0;
      wd_lo_q     <= '0;
      wd_hi_q     <= '0;
      rdata_lo_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= finish;
      if (accept) begin
        we_q     <= req_we_i;
        signed_q <= req_signed_i;
        split_q  <= map_split;
        err_lo_q <= 1'b0;
        base_q   <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        off_q    <= req_addr_i[OFF_W-1:0];
        size_q   <= req_size_i;
        be_lo_q  <= map_be_lo;
        be_hi_q  <= map_be_hi;
        wd_lo_q  <= map_wd_lo;
        wd_hi_q  <= map_wd_hi;
      end
      if (resp_lo) begin
        rdata_lo_q <= bus_rdata_i;
        err_lo_q   <= bus_err_i;
      end
      if (finish) begin
        rsp_err_q   <= bus_err_i | (resp_hi & err_lo_q);
        rsp_rdata_q <= we_q ? '0 : merged;
      end
    end
  end

  assign bus_we_o    = we_q;
  assign bus_addr_o  = in_hi ? base_q + WORD_STEP : base_q;
  assign bus_be_o    = in_hi ? be_hi_q : be_lo_q;
  assign bus_wdata_o = in_hi ? wd_hi_q : wd_lo_q;

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BYTES-1:0]  bus_be_o,
  input logic [DATA_W-1:0] bus_wdata_o
);

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> bus_req_o && !req_ready_o);

  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o);

  assert_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_be_o != '0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
                               && $stable(bus_we_o) && $stable(bus_wdata_o));

  assert_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> !bus_req_o);

  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && !req_valid_i |=> req_ready_o && !rsp_valid_o);

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

bind ldst_unit ldst_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_be_o    (bus_be_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/ldst_unit_tb.sv
module ldst_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_signed = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic        bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [3:0]  bus_be_o;
  logic        bus_gnt, bus_rvalid, bus_err;
  logic [31:0] bus_rdata;

  always #2 clk = ~clk;

  ldst_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_signed_i(req_signed),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
    .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [16];
  logic [7:0]  refb [64];
  int          log_n, resp_n, last_rsp_cyc;
  logic [31:0] log_addr [4], log_wd [4];
  logic [3:0]  log_be [4];
  logic        log_we [4];
  bit          err_plan [2];
  bit          spur_idle = 0, spur_wait = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural memory slave with random grant and response latency.
  initial begin : slave
    bit pend, hold_v, real_rsp;
    int lat, wait_n, idx;
    logic [31:0] pend_data, hold_addr, hold_wd;
    logic [3:0] hold_be;
    logic hold_we, pend_err;
    pend = 0; hold_v = 0; wait_n = 0; lat = 0;
    bus_gnt = 0; bus_rvalid = 0; bus_err = 0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_gnt = 0; bus_rvalid = 0; bus_err = 0; bus_rdata = $urandom;
      real_rsp = 0;
      if (!rst_n) begin
        pend = 0; hold_v = 0;
      end else if (pend) begin
        if (lat == 0) begin
          bus_rvalid = 1; bus_rdata = pend_data; bus_err = pend_err;
          pend = 0; resp_n++; last_rsp_cyc = cyc; real_rsp = 1;
        end else lat--;
      end else if (bus_req_o) begin
        if (hold_v)
          chk(bus_addr_o == hold_addr && bus_be_o == hold_be && bus_we_o == hold_we
              && bus_wdata_o == hold_wd, "R4 request fields held until grant", bus_addr_o, hold_addr);
        if (wait_n >= 4 || $urandom % 3 == 0) begin
          bus_gnt = 1; hold_v = 0; wait_n = 0;
          if (log_n < 4) begin
            log_addr[log_n] = bus_addr_o; log_be[log_n] = bus_be_o;
            log_we[log_n] = bus_we_o; log_wd[log_n] = bus_wdata_o;
          end
          idx = int'(bus_addr_o[5:2]);
          if (bus_we_o)
            for (int b = 0; b < 4; b++)
              if (bus_be_o[b]) mem[idx][b*8 +: 8] = bus_wdata_o[b*8 +: 8];
          pend_data = mem[idx];
          pend_err = (log_n < 2) ? err_plan[log_n] : 1'b0;
          log_n++; pend = 1; lat = $urandom % 3;
        end else begin
          hold_v = 1; hold_addr = bus_addr_o; hold_be = bus_be_o;
          hold_we = bus_we_o; hold_wd = bus_wdata_o; wait_n++;
          if (spur_wait && $urandom % 2 == 0) begin bus_rvalid = 1; bus_err = 1; end
        end
      end else begin
        if (hold_v) chk(0, "R4 request dropped before grant", 0, 1);
        hold_v = 0;
        if (spur_idle) begin bus_rvalid = 1; bus_err = 1; end
      end
      if (real_rsp) begin
        #1;
        chk(bus_req_o == 1'b0, "R10 request low while response presented", bus_req_o, 0);
      end
    end
  end

  task automatic do_access(input bit we, input logic [31:0] addr, input logic [1:0] sz,
                           input logic [31:0] wd, input bit sg, input bit e0, input bit e1,
                           input string what);
    int nb, parts, t;
    logic [31:0] ea [2];
    logic [31:0] ewd [2];
    logic [3:0]  ebe [2];
    logic [31:0] exp_rd;
    bit eerr;
    nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    ea[0] = {addr[31:2], 2'b00}; ea[1] = ea[0] + 32'd4;
    ebe[0] = '0; ebe[1] = '0; ewd[0] = '0; ewd[1] = '0; exp_rd = '0;
    for (int i = 0; i < nb; i++) begin
      logic [31:0] a;
      int p;
      a = addr + 32'(i);
      p = (a[31:2] != addr[31:2]) ? 1 : 0;
      ebe[p][a[1:0]] = 1'b1;
      ewd[p][a[1:0]*8 +: 8] = wd[i*8 +: 8];
      exp_rd[i*8 +: 8] = refb[a[5:0]];
      if (we) refb[a[5:0]] = wd[i*8 +: 8];
    end
    parts = (ebe[1] != 0) ? 2 : 1;
    if (we) exp_rd = '0;
    else if (nb == 1 && sg) exp_rd[31:8] = {24{exp_rd[7]}};
    else if (nb == 2 && sg) exp_rd[31:16] = {16{exp_rd[15]}};
    eerr = e0 | (parts == 2 && e1);
    log_n = 0; resp_n = 0; err_plan[0] = e0; err_plan[1] = e1;

    @(negedge clk);
    chk(req_ready_o == 1'b1, {"R1 ready when idle ", what}, req_ready_o, 1);
    req_valid = 1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd; req_signed = sg;
    @(negedge clk);
    req_valid = 0; req_addr = $urandom; req_wdata = $urandom;
    chk(bus_req_o == 1'b1 && req_ready_o == 1'b0, {"R1 request after accept ", what}, bus_req_o, 1);
    t = 0;
    while (!rsp_valid_o && t < 300) begin @(negedge clk); t++; end
    chk(rsp_valid_o == 1'b1, {"R9 completion seen ", what}, rsp_valid_o, 1);
    chk(cyc == last_rsp_cyc + 1, {"R9 completion one cycle after final response ", what}, cyc, last_rsp_cyc + 1);
    chk(log_n == parts, {"R3 transfer count ", what}, log_n, parts);
    chk(resp_n == parts, {"R8 all responses before completion ", what}, resp_n, parts);
    for (int p = 0; p < parts && p < log_n; p++) begin
      chk(log_addr[p] == ea[p], {"R3 transfer address ", what}, log_addr[p], ea[p]);
      chk(log_be[p] == ebe[p], {"R2 byte enables ", what}, log_be[p], ebe[p]);
      chk(log_we[p] == we, {"R2 write flag ", what}, log_we[p], we);
      if (we) chk((log_wd[p] & {{8{ebe[p][3]}}, {8{ebe[p][2]}}, {8{ebe[p][1]}}, {8{ebe[p][0]}}}) == ewd[p],
                  {"R2 store lanes ", what}, log_wd[p], ewd[p]);
    end
    chk(rsp_err_o == eerr, {(parts == 2) ? "R8 combined error " : "R9 error flag ", what}, rsp_err_o, eerr);
    if (!eerr) chk(rsp_rdata_o == exp_rd, {"R7 result data ", what}, rsp_rdata_o, exp_rd);
    @(negedge clk);
    chk(rsp_valid_o == 1'b0, {"R9 single pulse ", what}, rsp_valid_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int w = 0; w < 16; w++) begin
      mem[w] = $urandom;
      for (int b = 0; b < 4; b++) refb[w*4 + b] = mem[w][b*8 +: 8];
    end
    mem[5][31:24] = 8'h9c; refb[23] = 8'h9c;
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1 && bus_req_o == 1'b0 && rsp_valid_o == 1'b0,
        "R11 reset state", {req_ready_o, bus_req_o, rsp_valid_o}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    do_access(0, 32'd8,  2'b10, '0, 0, 0, 0, "R2 aligned word load");
    for (int o = 0; o < 4; o++) do_access(0, 32'd20 + 32'(o), 2'b00, '0, 1, 0, 0, "R7 signed byte");
    do_access(0, 32'd23, 2'b00, '0, 0, 0, 0, "R7 unsigned byte");
    do_access(1, 32'd34, 2'b00, 32'h5a, 0, 0, 0, "R2 byte store");
    do_access(1, 32'd45, 2'b10, 32'h11223344, 0, 0, 0, "R3 split word store");
    do_access(0, 32'd45, 2'b10, '0, 0, 0, 0, "R3 split word readback");
    do_access(0, 32'd23, 2'b01, '0, 1, 0, 0, "R3 split signed half");
    do_access(0, 32'd62, 2'b10, '0, 0, 0, 0, "R7 offset two word");
    do_access(0, 32'd49, 2'b10, '0, 0, 1, 0, "R8 error first half");
    do_access(0, 32'd50, 2'b10, '0, 0, 0, 1, "R8 error second half");
    do_access(1, 32'd51, 2'b01, 32'hbeef, 0, 1, 1, "R8 error both halves");
    do_access(0, 32'd12, 2'b10, '0, 0, 0, 1, "R9 unused second error");

    spur_idle = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(rsp_valid_o == 1'b0 && req_ready_o == 1'b1, "R6 stray response while idle",
          {rsp_valid_o, req_ready_o}, 2'b01);
    end
    spur_idle = 0;
    do_access(0, 32'd8, 2'b10, '0, 0, 0, 0, "R6 access after stray responses");

    spur_wait = 1;
    do_access(0, 32'd27, 2'b10, '0, 0, 0, 0, "R5 stray response before grant");
    for (int n = 0; n < 300; n++)
      do_access($urandom % 2, 32'($urandom % 64), 2'($urandom % 3), $urandom, $urandom % 2,
                ($urandom % 6) == 0, ($urandom % 6) == 0, "R5 random");
    spur_wait = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule